// File: doc/BRIEF.md
# Burst Command and Address Sequencer

This block sits in front of a synchronous burst memory core. On each rising clock edge it samples three active-level command strobes, a base word address and a burst-order select. It turns them into one of three operations: load a new burst, continue the current burst, or idle. From the operation it produces the internal word address for the current beat, along with the attributes of the burst: read or write, and single or double data rate.

A burst starts with a load. It grows by one beat for each continue command, up to four beats. Only the two low address bits move. They follow either an XOR-interleaved sequence or a linear modulo-4 sequence, as chosen when the burst was loaded. If further continues arrive, the sequence wraps around.

An output-enable timing signal trails read beats by one cycle, so a data path can drive read data one edge after the address was registered. The enable falls one cycle after an idle command or a write beat. A continue with no burst open is flagged and otherwise ignored.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are all zero: `word_addr`, `rd_op`, `dual_rate`, `beat_vld`, `q_drive` and `cont_err`.
- R2: A load (`ld_n`=0) sampled at an edge makes the outputs after that edge show `word_addr` = `base_addr`, `beat_vld`=1, `rd_op` = `rw_sel` (1 is read, 0 is write) and `dual_rate` = NOT `sdr_sel` (`sdr_sel`=1 is single rate).
- R3: An idle command (`ld_n`=1, `rw_sel`=0) drives `beat_vld` to 0 after that edge and closes the open burst.
- R4: For a burst loaded with `il_order`=1, the k-th continue gives `word_addr[1:0]` = start XOR k, where start is `base_addr[1:0]` at the load.
- R5: For a burst loaded with `il_order`=0, the k-th continue gives `word_addr[1:0]` = (start + k) mod 4.
- R6: During a continue (`ld_n`=1, `rw_sel`=1), `word_addr[AW-1:2]`, `rd_op` and `dual_rate` keep their values from the load. `sdr_sel` and `base_addr` have no effect.
- R7: A 4th continue after a load returns `word_addr[1:0]` to the start value. Later continues keep following the same modulo-4 pattern.
- R8: A continue sampled with no burst open raises `cont_err` for exactly one cycle. It leaves `beat_vld` at 0 and `word_addr` unchanged.
- R9: `q_drive` is 1 in the cycle after a cycle that showed `beat_vld`=1 with `rd_op`=1, and 0 otherwise. It is therefore low one cycle after an idle command has dropped `beat_vld`.
- R10: A load accepted while a burst is open restarts the beat count at the new base, with the new attributes.
- R11: `il_order` is sampled only by a load. Changing it during continues does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Low: load a new burst |
| rw_sel | input | 1 | With load: 1 read, 0 write. With ld_n high: 1 continue, 0 idle |
| sdr_sel | input | 1 | With load: 1 single rate, 0 double rate |
| base_addr | input | AW | Starting word address of a load |
| il_order | input | 1 | With load: 1 interleaved order, 0 linear order |
| word_addr | output | AW | Internal address of the current beat |
| rd_op | output | 1 | Current burst is a read |
| dual_rate | output | 1 | Current burst is double data rate |
| beat_vld | output | 1 | A burst beat is presented this cycle |
| q_drive | output | 1 | Output-enable timing, one cycle behind read beats |
| cont_err | output | 1 | One-cycle flag for a continue with no open burst |

## Verification
Two of the block's functions coincide when a new load follows straight after a read beat. In that cycle the counter restarts at the new base, and the output enable is still high because of the previous read beat. Near-exhaustive sweeps provoke this by ending bursts on every order, start value, direction, rate and length, then running back-to-back loads. A long stream of mixed commands follows, with loads landing on every beat position. Each cycle is judged against an arithmetic model of the address sequence that runs in lockstep and keeps the enable one cycle behind the beat.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_CONT = 2'd2
    } cmd_e;

    localparam int BEAT_W = 2;

    typedef struct packed {
        logic              rd;
        logic              dual;
        logic              il;
        logic [BEAT_W-1:0] start;
    } burst_attr_t;

    function automatic logic [BEAT_W-1:0] beat_lo(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] cnt,
        input logic              il
    );
        return il ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
    import bseq_pkg::*;
(
    input  logic ld_n,
    input  logic rw_sel,
    output cmd_e cmd
);
    always_comb begin
        if (!ld_n)       cmd = CMD_LOAD;
        else if (rw_sel) cmd = CMD_CONT;
        else             cmd = CMD_IDLE;
    end
endmodule

// File: rtl/bseq_counter.sv
module bseq_counter
    import bseq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_e          cmd,
    input  logic [AW-1:0] base_addr,
    input  logic          rw_sel,
    input  logic          sdr_sel,
    input  logic          il_order,
    output logic [AW-1:0] word_addr,
    output logic          rd_op,
    output logic          dual_rate,
    output logic          beat_vld,
    output logic          cont_err
);
    localparam int UPW = AW - BEAT_W;

    logic              active;
    logic [BEAT_W-1:0] cnt;
    logic [BEAT_W-1:0] lo;
    logic [UPW-1:0]    upper;
    burst_attr_t       attr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cnt      <= '0;
            lo       <= '0;
            upper    <= '0;
            attr     <= '0;
            beat_vld <= 1'b0;
            cont_err <= 1'b0;
        end else begin
            cont_err <= 1'b0;
            case (cmd)
                CMD_LOAD: begin
                    active     <= 1'b1;
                    cnt        <= '0;
                    attr.rd    <= rw_sel;
                    attr.dual  <= ~sdr_sel;
                    attr.il    <= il_order;
                    attr.start <= base_addr[BEAT_W-1:0];
                    upper      <= base_addr[AW-1:BEAT_W];
                    lo         <= base_addr[BEAT_W-1:0];
                    beat_vld   <= 1'b1;
                end
                CMD_CONT: begin
                    if (active) begin
                        cnt      <= cnt + 1'b1;
                        lo       <= beat_lo(attr.start, cnt + 1'b1, attr.il);
                        beat_vld <= 1'b1;
                    end else begin
                        cont_err <= 1'b1;
                        beat_vld <= 1'b0;
                    end
                end
                default: begin
                    active   <= 1'b0;
                    beat_vld <= 1'b0;
                end
            endcase
        end
    end

    assign word_addr = {upper, lo};
    assign rd_op     = attr.rd;
    assign dual_rate = attr.dual;

    a_r2_load_presents_base: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_LOAD |=> beat_vld && word_addr == $past(base_addr));

    a_r3_idle_drops_beat: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_IDLE |=> !beat_vld);

    a_r6_upper_held: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CONT && beat_vld) |=>
            word_addr[AW-1:BEAT_W] == $past(word_addr[AW-1:BEAT_W])
            && $stable(rd_op) && $stable(dual_rate));

    a_r8_idle_cont_flag: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CONT && !beat_vld) |=> cont_err && !beat_vld && $stable(word_addr));

    a_r8_flag_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cont_err |-> !beat_vld);
endmodule

// File: rtl/bseq_oe.sv
module bseq_oe (
    input  logic clk,
    input  logic rst,
    input  logic beat_vld,
    input  logic rd_op,
    output logic q_drive
);
    always_ff @(posedge clk) begin
        if (rst) q_drive <= 1'b0;
        else     q_drive <= beat_vld & rd_op;
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import bseq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          rw_sel,
    input  logic          sdr_sel,
    input  logic [AW-1:0] base_addr,
    input  logic          il_order,
    output logic [AW-1:0] word_addr,
    output logic          rd_op,
    output logic          dual_rate,
    output logic          beat_vld,
    output logic          q_drive,
    output logic          cont_err
);
    cmd_e cmd;

    bseq_decode u_dec (
        .ld_n   (ld_n),
        .rw_sel (rw_sel),
        .cmd    (cmd)
    );

    bseq_counter #(.AW(AW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .base_addr (base_addr),
        .rw_sel    (rw_sel),
        .sdr_sel   (sdr_sel),
        .il_order  (il_order),
        .word_addr (word_addr),
        .rd_op     (rd_op),
        .dual_rate (dual_rate),
        .beat_vld  (beat_vld),
        .cont_err  (cont_err)
    );

    bseq_oe u_oe (
        .clk      (clk),
        .rst      (rst),
        .beat_vld (beat_vld),
        .rd_op    (rd_op),
        .q_drive  (q_drive)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !beat_vld && !q_drive && !cont_err);

    a_r9_hiz_after_idle: assert property (@(posedge clk) disable iff (rst)
        (ld_n && !rw_sel) |=> ##1 !q_drive);

    a_r9_write_load_no_drive: assert property (@(posedge clk) disable iff (rst)
        (!ld_n && !rw_sel) |=> ##1 !q_drive);
endmodule

// File: tb/test_burst_seq.sv
`timescale 1ns/1ps
module test_burst_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_n = 1'b1;
    logic          rw_sel = 1'b0;
    logic          sdr_sel = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          il_order = 1'b0;
    logic [AW-1:0] word_addr;
    logic          rd_op, dual_rate, beat_vld, q_drive, cont_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic          m_act = 0, m_il = 0, m_rd = 0, m_ddr = 0, m_vld = 0, m_qd = 0, m_err = 0;
    logic [1:0]    m_cnt = 0, m_start = 0;
    logic [AW-1:0] m_addr = '0;

    always #2.5 clk = ~clk;

    burst_seq #(.AW(AW)) i_burst_seq (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rw_sel(rw_sel), .sdr_sel(sdr_sel),
        .base_addr(base_addr), .il_order(il_order), .word_addr(word_addr),
        .rd_op(rd_op), .dual_rate(dual_rate), .beat_vld(beat_vld),
        .q_drive(q_drive), .cont_err(cont_err)
    );

    task automatic chk(input string tg, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tg, act, exp, $time);
        end
    endtask

    task automatic step(input logic l, input logic r, input logic s,
                        input logic [AW-1:0] a, input logic o, input string tg);
        logic nq;
        @(negedge clk);
        ld_n = l; rw_sel = r; sdr_sel = s; base_addr = a; il_order = o;
        @(posedge clk);
        nq = m_vld & m_rd;
        m_err = 1'b0;
        if (!l) begin
            m_act = 1; m_cnt = 0; m_start = a[1:0]; m_il = o;
            m_addr = a; m_rd = r; m_ddr = !s; m_vld = 1;
        end else if (r) begin
            if (m_act) begin
                m_cnt = m_cnt + 2'd1;
                m_addr[1:0] = m_il ? (m_start ^ m_cnt) : 2'((m_start + m_cnt) % 4);
                m_vld = 1;
            end else begin
                m_err = 1; m_vld = 0;
            end
        end else begin
            m_act = 0; m_vld = 0;
        end
        m_qd = nq;
        #1;
        chk(tg, word_addr[1:0], m_addr[1:0]);
        chk("R6", word_addr[AW-1:2], m_addr[AW-1:2]);
        chk("R6", rd_op, m_rd);
        chk("R6", dual_rate, m_ddr);
        chk("R3", beat_vld, m_vld);
        chk("R9", q_drive, m_qd);
        chk("R8", cont_err, m_err);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1", word_addr, 0); chk("R1", rd_op, 0); chk("R1", dual_rate, 0);
        chk("R1", beat_vld, 0); chk("R1", q_drive, 0); chk("R1", cont_err, 0);
        @(negedge clk) rst = 1'b0;

        // R8: continue right after reset, nothing open
        step(1, 1, 0, 20'h12345, 0, "R8");
        step(1, 1, 1, 20'h0abcd, 1, "R8");

        // near-exhaustive sweep of order, start, direction, rate and length
        for (int il = 0; il < 2; il++)
            for (int st = 0; st < 4; st++)
                for (int rw = 0; rw < 2; rw++)
                    for (int sd = 0; sd < 2; sd++)
                        for (int n = 0; n < 7; n++) begin
                            logic [AW-1:0] a;
                            a = AW'($urandom);
                            a[1:0] = 2'(st);
                            step(0, 1'(rw), 1'(sd), a, 1'(il), "R2");
                            for (int k = 1; k <= n; k++)
                                step(1, 1, 1'($urandom % 2), AW'($urandom), 1'($urandom % 2),
                                     (k > 3) ? "R7" : (il != 0 ? "R4" : "R5"));
                            step(1, 0, 0, '0, 0, "R3");
                            if (n % 2 == 0) step(1, 1, 0, '1, 0, "R8");
                            step(1, 0, 1, '0, 1, "R9");
                        end

        // R11: order flips during continues have no effect
        step(0, 1, 1, 20'h00001, 0, "R11");
        step(1, 1, 1, '0, 1, "R11");
        step(1, 1, 1, '0, 1, "R11");
        step(1, 1, 1, '0, 1, "R11");

        // R10: back-to-back loads with open bursts, read then write
        step(0, 1, 0, 20'h55552, 1, "R10");
        step(1, 1, 0, '0, 0, "R10");
        step(0, 0, 1, 20'h33331, 0, "R10");
        step(1, 1, 1, '0, 1, "R10");
        step(0, 1, 1, 20'h77773, 1, "R10");
        step(0, 1, 0, 20'h11110, 0, "R10");
        step(1, 1, 0, '0, 0, "R10");

        // mixed command stream
        for (int i = 0; i < 3000; i++) begin
            int u;
            u = int'($urandom % 8);
            step((u < 2) ? 1'b0 : 1'b1, (u == 7) ? 1'b0 : 1'($urandom % 2),
                 1'($urandom % 2), AW'($urandom), 1'($urandom % 2), "R10");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule